// File: doc/BRIEF.md
# Banked Clock Fanout Divider

This block is a digital model of a clock fanout stage. It picks one of three free-running source clocks: a primary clock or one of two test clocks. It then sends the chosen clock to several output banks. Each bank has its own divide select. With that select low, the bank's lanes copy the source at full rate. With it high, the lanes carry the source divided by two.

The full-rate path and the half-rate path are built from the same pair of flops, so both rates take their rising edges from the same source rising edge. A single active-high master-reset / output-enable input does two things: it clears every divider flop, and it puts every output lane into high impedance. After release, every bank starts from the same phase.

The bank count and the lane count per bank are parameters. The default build has four banks of 2, 3, 4 and 6 lanes, giving 15 lanes.

Top module: `clk_fanout_div`

## Requirements
- R1: When `prim_sel` is high, the source clock is `prim_clk`, whatever the value of `tst_sel`.
- R2: When `prim_sel` is low, the source clock is `tst_clk0` if `tst_sel` is low and `tst_clk1` if `tst_sel` is high.
- R3: A bank whose `div_sel` bit is low drives its lanes with the source period. Its lanes are low just before each source rising edge and high just after it.
- R4: A bank whose `div_sel` bit is high drives its lanes at twice the source period. Its lanes toggle on every source rising edge.
- R5: While `mr_oe` is high, every bit of `q_out` is high impedance.
- R6: All lanes of one bank carry the same value whenever they are driven.
- R7: After `mr_oe` falls, all lanes are driven low until the next source rising edge. At that edge, every lane of every bank rises together, so half-rate banks are in phase with each other and with full-rate banks.
- R8: Lanes are packed with bank 0 at bit 0 and each bank above the previous one. In the default build, bank 0 is bits 1:0, bank 1 is bits 4:2, bank 2 is bits 8:5 and bank 3 is bits 14:9. Bit b of `div_sel` controls bank b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| prim_clk | input | 1 | Primary source clock |
| tst_clk0 | input | 1 | Test source clock 0 |
| tst_clk1 | input | 1 | Test source clock 1 |
| prim_sel | input | 1 | High selects the primary clock, low selects the test path |
| tst_sel | input | 1 | Selects the test clock: low for 0, high for 1 |
| div_sel | input | NUM_BANKS | Per-bank divide select: high for half rate |
| mr_oe | input | 1 | High clears the divider flops and floats all lanes |
| q_out | output | NUM_OUT (15) | Clock lanes of all banks, tri-stateable |

## Verification
The bench builds the block with its default four banks of 2, 3, 4 and 6 lanes. It drives the three sources at distinct periods (10, 14 and 18 ns), so a measured lane period shows which source was chosen. It sweeps all three source choices against all sixteen divide-select patterns. Because the bank sizes differ, a lane-to-bank packing error shows up as a wrong level or period on a specific bit. Each combination is entered through a reset pulse, which covers the high-impedance state, the release level and the common first rising edge.

// File: rtl/cfd_pkg.sv
`timescale 1ns/1ps
package cfd_pkg;
   localparam int MAX_BANKS = 32;
   localparam int SIZE_W    = 8;
   typedef logic [MAX_BANKS*SIZE_W-1:0] size_vec_t;

   // First lane index of bank `upto` (sum of sizes of lower banks)
   function automatic int lane_base(input size_vec_t sizes, input int upto);
      int acc;
      acc = 0;
      for (int i = 0; i < MAX_BANKS; i++)
         if (i < upto) acc += int'(sizes[i*SIZE_W +: SIZE_W]);
      return acc;
   endfunction
endpackage

// File: rtl/cfd_src_sel.sv
`timescale 1ns/1ps
module cfd_src_sel (
   input  logic prim_clk,
   input  logic tst_clk0,
   input  logic tst_clk1,
   input  logic prim_sel,
   input  logic tst_sel,
   output logic clk_o
);
   logic test_clk;
   always_comb begin
      test_clk = tst_sel ? tst_clk1 : tst_clk0;
      clk_o    = prim_sel ? prim_clk : test_clk;
   end
endmodule

// File: rtl/cfd_bank.sv
`timescale 1ns/1ps
module cfd_bank #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             half_sel,
   output logic [WIDTH-1:0] lanes
);
   logic rise_q;   // toggles on every rising edge: half-rate phase
   logic fall_q;   // follows rise_q on falling edge
   logic lane_val;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) rise_q <= 1'b0;
      else     rise_q <= ~rise_q;
   end

   always_ff @(negedge clk or posedge rst) begin
      if (rst) fall_q <= 1'b0;
      else     fall_q <= rise_q;
   end

   // full rate: high between a rising edge and the following falling edge
   assign lane_val = half_sel ? rise_q : (rise_q ^ fall_q);
   assign lanes    = {WIDTH{lane_val}};
endmodule

// File: rtl/clk_fanout_div.sv
`timescale 1ns/1ps
module clk_fanout_div
   import cfd_pkg::*;
#(
   parameter int                        NUM_BANKS  = 4,
   parameter logic [NUM_BANKS*SIZE_W-1:0] BANK_SIZES = {8'd6, 8'd4, 8'd3, 8'd2},
   localparam int NUM_OUT = lane_base(size_vec_t'(BANK_SIZES), NUM_BANKS)
) (
   input  logic                 prim_clk,
   input  logic                 tst_clk0,
   input  logic                 tst_clk1,
   input  logic                 prim_sel,
   input  logic                 tst_sel,
   input  logic [NUM_BANKS-1:0] div_sel,
   input  logic                 mr_oe,
   output wire  [NUM_OUT-1:0]   q_out
);
   localparam size_vec_t SIZES = size_vec_t'(BANK_SIZES);

   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("clk_fanout_div: NUM_BANKS out of range");
   end

   logic               sel_clk;
   logic [NUM_OUT-1:0] lanes;

   cfd_src_sel u_src (
      .prim_clk (prim_clk),
      .tst_clk0 (tst_clk0),
      .tst_clk1 (tst_clk1),
      .prim_sel (prim_sel),
      .tst_sel  (tst_sel),
      .clk_o    (sel_clk)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int BW   = int'(SIZES[b*SIZE_W +: SIZE_W]);
      localparam int BASE = lane_base(SIZES, b);
      if (BW < 1) begin : g_bad_size
         $error("clk_fanout_div: empty bank");
      end
      cfd_bank #(.WIDTH(BW)) u_bank (
         .clk      (sel_clk),
         .rst      (mr_oe),
         .half_sel (div_sel[b]),
         .lanes    (lanes[BASE +: BW])
      );
   end

   assign q_out = mr_oe ? {NUM_OUT{1'bz}} : lanes;
endmodule

// File: rtl/cfd_checker.sv
`timescale 1ns/1ps
module cfd_checker
   import cfd_pkg::*;
#(
   parameter int                          NUM_BANKS  = 4,
   parameter logic [NUM_BANKS*SIZE_W-1:0] BANK_SIZES = {8'd6, 8'd4, 8'd3, 8'd2},
   parameter int                          NUM_OUT    = 15
) (
   input logic                 sel_clk,
   input logic                 mr_oe,
   input logic [NUM_BANKS-1:0] div_sel,
   input logic [NUM_OUT-1:0]   q_out
);
   localparam size_vec_t SIZES = size_vec_t'(BANK_SIZES);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
      localparam int BW   = int'(SIZES[b*SIZE_W +: SIZE_W]);
      localparam int BASE = lane_base(SIZES, b);

      // R3: full-rate lane is low just before each source rising edge
      a_r3_full_low_pre_rise: assert property (@(posedge sel_clk) disable iff (mr_oe)
         (!div_sel[b] && $past(!mr_oe)) |-> (q_out[BASE] == 1'b0));

      // R4: half-rate lane flips between consecutive source rising edges
      a_r4_half_toggles: assert property (@(posedge sel_clk) disable iff (mr_oe)
         (div_sel[b] && $past(div_sel[b]) && $past(!mr_oe)) |-> (q_out[BASE] != $past(q_out[BASE])));

      // R7: every half-rate bank matches bank 0 when both are halving
      if (b > 0) begin : g_phase
         a_r7_half_in_phase: assert property (@(posedge sel_clk) disable iff (mr_oe)
            (div_sel[0] && div_sel[b]) |-> (q_out[BASE] == q_out[0]));
      end

      // R6: lanes of one bank agree
      for (genvar j = 1; j < BW; j++) begin : g_same
         a_r6_bank_lanes_equal: assert property (@(posedge sel_clk) disable iff (mr_oe)
            1'b1 |-> (q_out[BASE+j] == q_out[BASE]));
      end
   end
endmodule

bind clk_fanout_div cfd_checker #(
   .NUM_BANKS  (NUM_BANKS),
   .BANK_SIZES (BANK_SIZES),
   .NUM_OUT    (NUM_OUT)
) u_chk (
   .sel_clk (sel_clk),
   .mr_oe   (mr_oe),
   .div_sel (div_sel),
   .q_out   (q_out)
);

// File: tb/clk_fanout_div_test.sv
`timescale 1ns/1ps
module clk_fanout_div_test;
   localparam int NB = 4;
   localparam int NO = 15;
   localparam int SZ [NB] = '{2, 3, 4, 6};

   logic tb_clk = 1'b0;
   always #2 tb_clk = ~tb_clk;   // 250 MHz

   logic pclk = 1'b0, t0 = 1'b0, t1 = 1'b0;
   always #5 pclk = ~pclk;       // 10 ns
   always #7 t0   = ~t0;         // 14 ns
   always #9 t1   = ~t1;         // 18 ns

   logic          psel = 1'b0, tsel = 1'b0, mr = 1'b1;
   logic [NB-1:0] dsel = '0;

   tri1 [NO-1:0] q_hi;   // floats high when undriven
   tri0 [NO-1:0] q_lo;   // floats low when undriven

   clk_fanout_div uut (
      .prim_clk(pclk), .tst_clk0(t0), .tst_clk1(t1),
      .prim_sel(psel), .tst_sel(tsel), .div_sel(dsel), .mr_oe(mr), .q_out(q_hi));
   clk_fanout_div uut_lo (
      .prim_clk(pclk), .tst_clk0(t0), .tst_clk1(t1),
      .prim_sel(psel), .tst_sel(tsel), .div_sel(dsel), .mr_oe(mr), .q_out(q_lo));

   wire bclk = psel ? pclk : (tsel ? t1 : t0);

   int total = 0, bad = 0, cyc = 0;
   real last [NO];
   real per  [NO];

   initial foreach (last[i]) begin last[i] = -1.0; per[i] = 0.0; end
   always @(posedge mr) foreach (last[i]) last[i] = -1.0;

   for (genvar i = 0; i < NO; i++) begin : g_mon
      always @(posedge q_hi[i]) begin
         if (!mr) begin
            if (last[i] >= 0.0) per[i] = $realtime - last[i];
            last[i] = $realtime;
         end
      end
   end

   function automatic int bank_of(input int lane);
      int acc;
      acc = 0;
      for (int b = 0; b < NB; b++) begin
         acc += SZ[b];
         if (lane < acc) return b;
      end
      return NB - 1;
   endfunction

   task automatic chk_v(input bit ok, input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic chk_r(input string req, input int lane, input real act, input real exp);
      total++;
      if (act < exp - 0.01 || act > exp + 0.01) begin
         bad++;
         $display("FAIL %s lane %0d: actual=%0.2f expected=%0.2f", req, lane, act, exp);
      end
   endtask

   task automatic run(input int src, input int d);
      logic [NO-1:0] half_mask;
      real           p;
      string         sreq;
      mr   = 1'b1;
      psel = (src == 2);
      tsel = (src == 1);
      dsel = d[NB-1:0];
      p    = (src == 2) ? 10.0 : ((src == 1) ? 18.0 : 14.0);
      sreq = (src == 2) ? "R1" : "R2";
      for (int i = 0; i < NO; i++) half_mask[i] = dsel[bank_of(i)];
      #40;
      // R5: floating lanes read as the pull value on each copy
      chk_v(q_hi == '1 && q_lo == '0, "R5 high-Z under reset", q_hi ^ q_lo, '1);
      @(negedge bclk); #1 mr = 1'b0; #1;
      chk_v(q_hi == '0 && q_lo == '0, "R7 driven low after release", q_hi | q_lo, '0);
      @(posedge bclk); #1;
      chk_v(q_hi == '1 && q_lo == '1, "R7 common first rise", q_hi & q_lo, '1);
      @(negedge bclk); #1;
      // R3 full-rate falls, R4 half-rate stays high, R8 lane-to-bank packing
      chk_v(q_hi == half_mask && q_lo == half_mask, "R3 R4 R8 level after first fall", q_hi, half_mask);
      repeat (5) @(posedge bclk);
      #1;
      for (int i = 0; i < NO; i++)
         chk_r(half_mask[i] ? {sreq, " R4 R8 half period"} : {sreq, " R3 R8 full period"},
               i, per[i], half_mask[i] ? 2.0 * p : p);
      for (int i = 0; i < NO; i++) begin
         int b0 = 0;
         for (int b = 0; b < bank_of(i); b++) b0 += SZ[b];
         chk_v(q_hi[i] == q_hi[b0] && q_hi[i] == q_lo[i], "R6 bank lanes equal", q_hi, {NO{q_hi[b0]}});
      end
   endtask

   initial begin
      #3;
      chk_v(q_hi == '1 && q_lo == '0, "R5 reset state high-Z", q_hi ^ q_lo, '1);
      for (int s = 0; s < 3; s++)
         for (int d = 0; d < 16; d++)
            run(s, d);
      // R1: primary wins regardless of the test select
      mr = 1'b1; psel = 1'b1; tsel = 1'b1; dsel = '0; #40;
      @(negedge bclk); #1 mr = 1'b0;
      repeat (4) @(posedge pclk);
      #1;
      chk_r("R1 primary overrides test select", 0, per[0], 10.0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   always @(posedge tb_clk) begin
      cyc++;
      if (cyc > 150000) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d cycles expected=below 150000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule